// File: doc/BRIEF.md
# Passive LCD Shift-Out Refresh Controller

This block refreshes a passive-matrix (STN) panel through an external column driver that takes pixel data over a narrow shift bus. Software sets the output mode, the frame buffer address, the pixel depth, the panel size and the refresh rate, then sets the run bit. From then on the block works through the panel one line at a time. It asks the host for the system bus, waits for the grant, reads the words of one line into a small local line store, and drops the request so the host can resume. It then sends the line to the driver 4 or 8 bits per base-clock period, and follows the line with a latch strobe.

Pixels are packed least-significant first as one continuous bit stream, so 3 bpp and 12 bpp pixels may straddle 32-bit word boundaries. In palette mode every stored byte selects one of 256 colours of 12 bits, and the 12-bit colours are the values sent to the driver. The base clock is the system clock divided by 16 and then by a programmable 8-bit count.

Top module: `lcd_sr_refresh`

## Requirements
- R1: After reset, and whenever the block is idle, lcd_pclk, lcd_latch, lcd_frame, bus_req and mem_rd are low and lcd_data is zero.
- R2: Once the run bit is set, bus_req rises. mem_rd is asserted only while bus_gnt is high. bus_req falls after the last read of a line, before the first lcd_pclk of that line.
- R3: Every line makes exactly ceil(width*mbpp/32) reads, where mbpp is the stored depth (8 in palette mode). Addresses rise by 4 from the base, line after line, and go back to the base at the first line of each frame. Read data is taken in the cycle mem_ack is high.
- R4: The depth code is 0,1,2,3,4,5 for 1,2,3,4,8,12 bits per pixel. Without the palette, the output stream is the line's memory bits in order, with bit 0 of the first word first.
- R5: With the palette bit set at depth code 4, each stored byte (byte 0 of a word first) is replaced by its 12-bit palette colour, and the stream is those colours back to back, LSB first.
- R6: With the bus bit set, a word carries 8 stream bits on lcd_data[7:0]. Otherwise it carries 4 bits on lcd_data[3:0], and lcd_data[7:4] is zero. Stream bits past the end of the line are sent as zero.
- R7: lcd_pclk pulses for one cycle with each new lcd_data word. A line has ceil(width*obpp/buswidth) words, where obpp is 12 in palette mode and the depth otherwise. lcd_pclk and lcd_latch never pulse in the same cycle.
- R8: lcd_latch pulses once per line, one base-clock period after the last word. lcd_frame pulses together with the latch of line 0 of each frame and at no other time.
- R9: Successive lcd_pclk pulses of a line, and the latch after the last one, are exactly 16*(rate+1) system cycles apart.
- R10: If the run bit is cleared, the line in progress (fetch and shift) is completed with its latch, and the block then goes idle with no further request or strobe.
- R11: Writes use reg_addr 0 for mode (bit0 8-bit bus, bits3:1 depth code, bit4 palette), 1 for base address, 2 for size (bits15:0 width in pixels, bits31:16 lines), 3 for rate (bits7:0), 4 for a palette write (bits11:0 colour, bits23:16 index) and 5 for run (bit0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| bus_req | output | 1 | System bus request to the host |
| bus_gnt | input | 1 | Bus grant from the host |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the 32-bit word being read |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| lcd_data | output | 8 | Shift data to the panel driver |
| lcd_pclk | output | 1 | Data shift strobe, one per word |
| lcd_latch | output | 1 | Line latch strobe |
| lcd_frame | output | 1 | First-line-of-frame strobe |

## Verification
The bench sweeps every depth code at both bus widths, and palette mode at both widths, with panel widths that make pixels straddle word boundaries and leave a partly filled last bus word. A fault in the unpacking shows as wrong data bits near 32-bit boundaries. A fault in the end-of-line mask shows as nonzero padding, and a fault in the word count as a wrong number of pixel clocks before the latch. Across a frame wrap it checks that the frame strobe marks only line 0 and that the read count restarts from the base, so an address that keeps running past the frame gives wrong data. It also clears the run bit while a line is in progress: a design that stops at once loses the last latch, and one that ignores the bit keeps requesting the bus.

// File: rtl/lcd_sr_pkg.sv
package lcd_sr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_FETCH = 2'd2,
    ST_SHIFT = 2'd3
  } lcd_state_e;

  localparam int CNT_W = 24;

  // depth code to bits per pixel
  function automatic logic [3:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd3;
      3'd3:    return 4'd4;
      3'd4:    return 4'd8;
      default: return 4'd12;
    endcase
  endfunction

  // 32-bit words needed to hold a number of bits
  function automatic logic [CNT_W-1:0] fetch_words(input logic [CNT_W-1:0] bits);
    return (bits + CNT_W'(31)) >> 5;
  endfunction

  // bus words needed to send a number of bits
  function automatic logic [CNT_W-1:0] bus_words(input logic [CNT_W-1:0] bits,
                                                 input logic bus8);
    return bus8 ? ((bits + CNT_W'(7)) >> 3) : ((bits + CNT_W'(3)) >> 2);
  endfunction

  // lanes of the current bus word that carry real stream bits
  function automatic logic [7:0] lane_mask(input logic [CNT_W-1:0] sent,
                                           input logic [CNT_W-1:0] total,
                                           input logic bus8);
    logic [7:0] m;
    for (int k = 0; k < 8; k++)
      m[k] = ((sent + CNT_W'(k)) < total) && (bus8 || (k < 4));
    return m;
  endfunction

endpackage

// File: rtl/lcd_sr_rategen.sv
module lcd_sr_rategen #(
  parameter int PRE   = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = (PRE > 1) ? $clog2(PRE) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_W'(PRE - 1));
  assign tick     = en && pre_wrap && (div_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!en) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_wrap ? '0 : pre_q + PRE_W'(1);
      if (pre_wrap) div_q <= (div_q == div) ? '0 : div_q + DIV_W'(1);
    end
  end

  // R9: base-clock ticks are never back to back
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/lcd_sr_linestore.sv
module lcd_sr_linestore #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [31:0]   rdata0,
  output logic [31:0]   rdata1
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];

endmodule

// File: rtl/lcd_sr_palette.sv
module lcd_sr_palette #(
  parameter int ENTRIES = 256,
  parameter int CW      = 12,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [CW-1:0] wcol,
  input  logic [IW-1:0] ridx0,
  input  logic [IW-1:0] ridx1,
  output logic [CW-1:0] rcol0,
  output logic [CW-1:0] rcol1
);
  logic [CW-1:0] tbl [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) tbl[widx] <= wcol;
  end

  assign rcol0 = tbl[ridx0];
  assign rcol1 = tbl[ridx1];

endmodule

// File: rtl/lcd_sr_refresh.sv
module lcd_sr_refresh
  import lcd_sr_pkg::*;
#(
  parameter int LB_WORDS = 64,
  parameter int PRE_DIV  = 16,
  parameter int PAL_N    = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        bus_req,
  input  logic        bus_gnt,
  output logic        mem_rd,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  lcd_data,
  output logic        lcd_pclk,
  output logic        lcd_latch,
  output logic        lcd_frame
);
  localparam int AW     = $clog2(LB_WORDS);
  localparam int PAL_AW = $clog2(PAL_N);
  localparam int CW     = 12;

  // programmed settings
  logic        m_bus8, m_pal, run_q;
  logic [2:0]  m_code;
  logic [31:0] base_q;
  logic [15:0] width_q, lines_q;
  logic [7:0]  rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bus8 <= 1'b0; m_pal <= 1'b0; m_code <= '0; run_q <= 1'b0;
      base_q <= '0; width_q <= '0; lines_q <= '0; rate_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: begin m_bus8 <= reg_wdata[0]; m_code <= reg_wdata[3:1]; m_pal <= reg_wdata[4]; end
        3'd1: base_q <= reg_wdata;
        3'd2: begin width_q <= reg_wdata[15:0]; lines_q <= reg_wdata[31:16]; end
        3'd3: rate_q <= reg_wdata[7:0];
        3'd5: run_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // derived geometry
  logic            pal_on;
  logic [3:0]      dbits, obits;
  logic [CNT_W-1:0] mem_bits, out_bits, wpl, nwords;

  assign dbits    = depth_bits(m_code);
  assign pal_on   = m_pal && (m_code == 3'd4);
  assign obits    = pal_on ? 4'd12 : dbits;
  assign mem_bits = CNT_W'(width_q) * CNT_W'(dbits);
  assign out_bits = CNT_W'(width_q) * CNT_W'(obits);
  assign wpl      = fetch_words(mem_bits);
  assign nwords   = bus_words(out_bits, m_bus8);

  // sequencing state
  lcd_state_e       st;
  logic [31:0]      faddr;
  logic [CNT_W-1:0] fcnt, ob, wcnt;
  logic [15:0]      line_q, pp;
  logic [3:0]       po;
  logic             tick;

  // named internal events
  logic ev_fill, ev_fetch_done, ev_word, ev_line_end;
  assign ev_fill       = (st == ST_FETCH) && mem_ack;
  assign ev_fetch_done = ev_fill && ((fcnt + CNT_W'(1)) >= wpl);
  assign ev_word       = (st == ST_SHIFT) && tick && (wcnt < nwords);
  assign ev_line_end   = (st == ST_SHIFT) && tick && (wcnt >= nwords);

  assign bus_req  = (st == ST_REQ) || (st == ST_FETCH);
  assign mem_rd   = (st == ST_FETCH);
  assign mem_addr = faddr;

  lcd_sr_rategen #(.PRE(PRE_DIV), .DIV_W(8)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(st == ST_SHIFT), .div(rate_q), .tick(tick)
  );

  // unpacking datapath
  logic [CNT_W-1:0] wsel;
  logic [5:0]       sh;
  logic [31:0]      rd0, rd1;
  logic [63:0]      win;
  logic [CW-1:0]    col0, col1;
  logic [23:0]      cwin;
  logic [7:0]       word_out;
  logic [4:0]       po_sum;
  logic [3:0]       step;

  assign wsel = pal_on ? CNT_W'(pp >> 2) : (ob >> 5);
  assign sh   = pal_on ? {1'b0, pp[1:0], 3'b000} : {1'b0, ob[4:0]};
  assign win  = {rd1, rd0} >> sh;
  assign cwin = {col1, col0} >> po;
  assign word_out = (pal_on ? cwin[7:0] : win[7:0]) & lane_mask(ob, out_bits, m_bus8);
  assign step   = m_bus8 ? 4'd8 : 4'd4;
  assign po_sum = {1'b0, po} + {1'b0, step};

  lcd_sr_linestore #(.WORDS(LB_WORDS)) u_line (
    .clk(clk), .we(ev_fill), .waddr(fcnt[AW-1:0]), .wdata(mem_rdata),
    .raddr0(wsel[AW-1:0]), .raddr1(wsel[AW-1:0] + AW'(1)),
    .rdata0(rd0), .rdata1(rd1)
  );

  lcd_sr_palette #(.ENTRIES(PAL_N), .CW(CW)) u_pal (
    .clk(clk), .we(reg_we && (reg_addr == 3'd4)),
    .widx(reg_wdata[16 +: PAL_AW]), .wcol(reg_wdata[CW-1:0]),
    .ridx0(win[PAL_AW-1:0]), .ridx1(win[8 +: PAL_AW]),
    .rcol0(col0), .rcol1(col1)
  );

  wire unused_bits = ^{win[63:16], cwin[23:8], wsel[CNT_W-1:AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; faddr <= '0; fcnt <= '0; ob <= '0; wcnt <= '0;
      line_q <= '0; pp <= '0; po <= '0;
      lcd_data <= '0; lcd_pclk <= 1'b0; lcd_latch <= 1'b0; lcd_frame <= 1'b0;
    end else begin
      lcd_pclk  <= 1'b0;
      lcd_latch <= 1'b0;
      lcd_frame <= 1'b0;
      unique case (st)
        ST_IDLE: if (run_q) begin
          st <= ST_REQ; line_q <= '0; faddr <= base_q;
        end
        ST_REQ: if (bus_gnt) begin
          st <= ST_FETCH; fcnt <= '0;
        end
        ST_FETCH: if (ev_fill) begin
          fcnt  <= fcnt + CNT_W'(1);
          faddr <= faddr + 32'd4;
          if (ev_fetch_done) begin
            st <= ST_SHIFT; ob <= '0; wcnt <= '0; pp <= '0; po <= '0;
          end
        end
        ST_SHIFT: begin
          if (ev_word) begin
            lcd_data <= word_out;
            lcd_pclk <= 1'b1;
            ob       <= ob + CNT_W'(step);
            wcnt     <= wcnt + CNT_W'(1);
            if (po_sum >= 5'd12) begin
              pp <= pp + 16'd1; po <= 4'(po_sum - 5'd12);
            end else begin
              po <= po_sum[3:0];
            end
          end else if (ev_line_end) begin
            lcd_data  <= '0;
            lcd_latch <= 1'b1;
            lcd_frame <= (line_q == 16'd0);
            if ((line_q + 16'd1) >= lines_q) begin
              line_q <= '0; faddr <= base_q;
            end else begin
              line_q <= line_q + 16'd1;
            end
            st <= run_q ? ST_REQ : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: reads only under grant
  p_rd_under_gnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> bus_gnt);
  // R2: bus released before shifting
  p_pclk_bus_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_pclk |-> !bus_req);
  // R2: request follows a set run bit
  p_req_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && run_q) |=> bus_req);
  // R1: idle stays quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> (!lcd_pclk && !lcd_latch && !bus_req && lcd_data == 8'd0));
  // R7: one strobe at a time
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_pclk |-> !lcd_latch);
  // R8: frame only with a latch
  p_frame_with_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_frame |-> lcd_latch);
  // R6: narrow bus keeps upper lanes clear
  p_narrow_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_pclk && !m_bus8) |-> (lcd_data[7:4] == 4'd0));

endmodule

// File: tb/tb_lcd_sr_refresh.sv
`timescale 1ns/1ps
module tb_lcd_sr_refresh;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        bus_req, bus_gnt, mem_rd, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic [7:0]  lcd_data;
  logic        lcd_pclk, lcd_latch, lcd_frame;

  always #2.5 clk = ~clk;

  lcd_sr_refresh dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .lcd_data(lcd_data),
    .lcd_pclk(lcd_pclk), .lcd_latch(lcd_latch), .lcd_frame(lcd_frame)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ (a >> 3) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [11:0] pal_model(input int i);
    return 12'((i * 37 + 5) & 12'hFFF);
  endfunction

  function automatic int bits_of(input int code);
    case (code)
      0: return 1; 1: return 2; 2: return 3; 3: return 4; 4: return 8;
      default: return 12;
    endcase
  endfunction

  // memory and host model
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; bus_gnt <= 1'b0; mem_rdata <= '0;
    end else begin
      bus_gnt   <= bus_req;
      mem_ack   <= mem_rd && !mem_ack;
      mem_rdata <= mem_word(mem_addr);
    end
  end

  // current configuration, written by the sequencer only
  int          cfg_seq = 0;
  int          cfg_code = 0, cfg_width = 1, cfg_lines = 2, cfg_div = 0;
  bit          cfg_bus8 = 0, cfg_pal = 0;
  logic [31:0] cfg_base = '0;

  function automatic int obpp();
    return cfg_pal ? 12 : bits_of(cfg_code);
  endfunction
  function automatic int mbpp();
    return cfg_pal ? 8 : bits_of(cfg_code);
  endfunction
  function automatic int exp_wpl();
    return (cfg_width * mbpp() + 31) / 32;
  endfunction
  function automatic int exp_nwords();
    int w = cfg_bus8 ? 8 : 4;
    return (cfg_width * obpp() + w - 1) / w;
  endfunction

  function automatic logic [7:0] exp_word(input int ln, input int j);
    logic [7:0] r = '0;
    int w = cfg_bus8 ? 8 : 4;
    int total = cfg_width * obpp();
    for (int k = 0; k < w; k++) begin
      int b = j * w + k;
      if (b < total) begin
        if (cfg_pal) begin
          int p = b / 12;
          int o = b % 12;
          logic [31:0] mw = mem_word(cfg_base + 32'((ln * exp_wpl() + p / 4) * 4));
          int idx = int'((mw >> (8 * (p % 4))) & 32'hFF);
          logic [11:0] c = pal_model(idx);
          r[k] = c[o];
        end else begin
          logic [31:0] mw = mem_word(cfg_base + 32'((ln * exp_wpl() + b / 32) * 4));
          r[k] = mw[b % 32];
        end
      end
    end
    return r;
  endfunction

  // monitor
  int     seen_seq = 0;
  int     line_idx = 0, word_idx = 0, reads = 0, latches = 0;
  longint cyc = 0, last_ev = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (seen_seq != cfg_seq) begin
        seen_seq = cfg_seq; line_idx = 0; word_idx = 0; reads = 0; latches = 0;
      end
      if (mem_rd) check(bus_gnt, "R2 read without grant", bus_gnt, 1);
      if (mem_ack) reads++;
      if (lcd_pclk) begin
        check(!bus_req, "R2 bus held during shift", bus_req, 0);
        check(lcd_data == exp_word(line_idx, word_idx),
              cfg_pal ? "R5 R6 palette word" : "R4 R6 data word",
              lcd_data, exp_word(line_idx, word_idx));
        if (word_idx > 0)
          check(cyc - last_ev == 16 * (cfg_div + 1), "R9 pclk spacing", cyc - last_ev, 16 * (cfg_div + 1));
        word_idx++;
        last_ev = cyc;
      end
      if (lcd_latch) begin
        check(word_idx == exp_nwords(), "R7 words per line", word_idx, exp_nwords());
        check(reads == exp_wpl(), "R3 reads per line", reads, exp_wpl());
        check(lcd_frame == (line_idx == 0), "R8 frame strobe", lcd_frame, line_idx == 0);
        if (word_idx > 0)
          check(cyc - last_ev == 16 * (cfg_div + 1), "R9 latch spacing", cyc - last_ev, 16 * (cfg_div + 1));
        line_idx = (line_idx + 1) % cfg_lines;
        word_idx = 0;
        reads = 0;
        latches++;
      end else if (lcd_frame) begin
        check(0, "R8 frame without latch", 1, 0);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!lcd_pclk && !lcd_latch && !lcd_frame && !bus_req && !mem_rd && lcd_data == 8'd0,
          "R1 reset outputs", {lcd_data, lcd_pclk, lcd_latch, lcd_frame, bus_req}, 0);

    // R11 palette load through register 4
    for (int i = 0; i < 256; i++) wr(3'd4, {8'd0, 8'(i), 4'd0, pal_model(i)});

    for (int i = 0; i < 14; i++) begin
      int quiet = 0;
      cfg_pal   = (i >= 12);
      cfg_code  = cfg_pal ? 4 : i / 2;
      cfg_bus8  = i[0];
      cfg_width = 13 + 3 * cfg_code + (cfg_pal ? 2 : 0);
      cfg_lines = 2;
      cfg_div   = (i == 7) ? 3 : 0;
      cfg_base  = 32'h1000 + 32'(i) * 32'h400;
      wr(3'd0, {27'd0, cfg_pal, 3'(cfg_code), cfg_bus8});
      wr(3'd1, cfg_base);
      wr(3'd2, {16'(cfg_lines), 16'(cfg_width)});
      wr(3'd3, 32'(cfg_div));
      cfg_seq++;
      @(negedge clk);
      // R1 still idle before run
      check(!bus_req && !lcd_pclk, "R1 idle before run", bus_req, 0);
      wr(3'd5, 32'd1);
      while (latches < 2) @(negedge clk);
      // R10 stop during line 2: it must still finish
      wr(3'd5, 32'd0);
      while (latches < 3) @(negedge clk);
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        if (lcd_pclk || lcd_latch || bus_req || lcd_data != 8'd0) quiet++;
      end
      check(quiet == 0, "R10 quiet after stop", quiet, 0);
      check(latches == 3, "R10 lines after stop", latches, 3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule